// File: doc/BRIEF.md
# Receive Word Buffer with Packet Status

This block sits between a receive deserializer and a host read port. The deserializer delivers one packet at a time as a stream of 16-bit words. Each word is kept in a 16-entry circular store together with a generated parity bit. The host reads the words back in order through a registered read port. The same port also returns a status word that describes the packet.

The buffer keeps 4-bit write and read pointers that wrap modulo 16. It exports four threshold flags on their difference. It counts the words offered for the packet. Words beyond the sixteenth are not stored. The eighteenth word marks the packet as overrun and discards it. After the packet's closing word, the input deasserts ready and stays closed until the host purges the packet. The status word holds sticky collision, overrun and misalignment bits, a 2-bit count of extra data reads and the number of readable words. An attention output rises once every stored word has been read.

Stream rules: a word transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high from reset and after a purge. It falls on the edge that accepts a word with `in_last` set. While ready is low, the source must hold its word. Nothing it offers has any effect. The read port has no back-pressure: each `rd_valid` cycle produces a result on the next edge.

Top module: `rx_word_buffer`

## Requirements
- R1: After reset, `in_ready`=1, `attn`=0, `rd_data`=0, `rd_par`=1, and the difference flags read `diff_ne0`=0, `diff_ne15`=1, `diff_ge4`=0, `diff_le11`=1.
- R2: Each accepted word among the first 16 of a packet is stored with a parity bit. A data read (`rd_valid`=1, `rd_sel`=0) of a stored word returns the words in arrival order on the next edge. On every data read, the XOR of the 16 `rd_data` bits and `rd_par` is 1.
- R3: With D = (write pointer − read pointer) mod 16, the flags are `diff_ne0` = (D≠0), `diff_ne15` = (D≠15), `diff_ge4` = (D≥4) and `diff_le11` = (D≤11). A stored word raises D by one, and a data read that returns a stored word lowers it by one.
- R4: A packet of 16 or 17 words never sets overrun. The 17th word is dropped, and only 16 words are stored. The 18th accepted word sets overrun (status bit 13) and discards the packet: the readable count becomes 0, the write pointer returns to the read pointer, and data reads no longer return new words.
- R5: A status read (`rd_valid`=1, `rd_sel`=1) returns, on the next edge, this word: bit 15 = collision seen while the packet was open, bit 13 = overrun, bit 8 = closing word flagged misaligned, bits 7:6 = extra-read count, bits 4:0 = readable word count (0 to 16). All other bits are 0. On a status read, `rd_par` gives odd parity over the word.
- R6: `attn` is 1 exactly when the packet is closed and the number of words read equals the readable count. This includes an overrun packet, which has a readable count of 0.
- R7: A data read when no unread stored word remains leaves `rd_data`, `rd_par` and both pointers unchanged. If the packet is closed, such a read raises the extra-read count, which saturates at 3.
- R8: `in_ready` falls after the edge that accepts a word with `in_last`=1. Words offered while it is low are not counted or stored.
- R9: A cycle with `purge_en`=1 and `done_pkt`=1 clears the collision, overrun and misalignment bits, the extra-read count, the word counts and both pointers, and reopens the input. A `done_pkt` pulse with `purge_en`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Receive word offered |
| in_ready | output | 1 | Buffer accepts a word this cycle |
| in_data | input | 16 | Received word |
| in_last | input | 1 | Offered word closes the packet |
| in_misalign | input | 1 | Closing word ended off a byte boundary |
| in_collision | input | 1 | Collision seen on the line |
| rd_valid | input | 1 | Host read strobe |
| rd_sel | input | 1 | 0 = data word, 1 = status word |
| rd_data | output | 16 | Registered read result |
| rd_par | output | 1 | Parity bit of the read result |
| purge_en | input | 1 | Purge mode enable |
| done_pkt | input | 1 | Host is finished with the packet |
| attn | output | 1 | All stored words have been read |
| diff_ne0 | output | 1 | Pointer difference not zero |
| diff_ne15 | output | 1 | Pointer difference not fifteen |
| diff_ge4 | output | 1 | Pointer difference at least four |
| diff_le11 | output | 1 | Pointer difference at most eleven |

## Verification
Several packet lengths are used: 5, 16, 17 and 18 words, plus a short packet that carries errors. Each length separates a different counting boundary. A length of 16 wraps the pointers back to zero difference. A length of 17 must drop its last word without flagging overrun, and a length of 18 must discard the whole packet. The 16-word fill checks every flag after every write, so each threshold edge is hit from both sides. The 5-word packet is followed by a run of extra reads that shows the held output and the saturating extra-read count. The error packet combines a collision, a misaligned closing word, words offered while closed and a `done_pkt` without purge. This separates the sticky bits from the purge that clears them.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // Status word bit positions
  localparam int ST_JAM   = 15;
  localparam int ST_OVR   = 13;
  localparam int ST_ALIGN = 8;
  localparam int ST_EXC_LO = 6;
  localparam int EXC_W    = 2;

  // Read port selector values
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  function automatic logic odd_fill(input logic [15:0] w);
    return ~(^w);
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_ptr,
  output logic [DW-1:0] rd_word,
  output logic          rd_pbit
);
  localparam int DEPTH = 1 << AW;

  logic [DW:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_ptr] <= {~(^wr_data), wr_data};
  end

  assign rd_word = cells[rd_ptr][DW-1:0];
  assign rd_pbit = cells[rd_ptr][DW];
endmodule

// File: rtl/rxb_ptrs.sv
module rxb_ptrs #(
  parameter int AW = 4,
  parameter int LO_MARK = 4,
  parameter int HI_MARK = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic          wr_last,
  input  logic          rd_req,
  input  logic          clear,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic          store_en,
  output logic          rd_adv,
  output logic          extra_rd,
  output logic          closed,
  output logic          ovr,
  output logic [AW:0]   stored,
  output logic          drained,
  output logic          f_ne0,
  output logic          f_ne15,
  output logic          f_ge4,
  output logic          f_le11
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(DEPTH + 3);
  localparam logic [CW-1:0] WC_DEPTH = CW'(DEPTH);
  localparam logic [CW-1:0] WC_TRIP  = CW'(DEPTH + 1);
  localparam logic [CW-1:0] WC_MAX   = '1;
  localparam logic [AW-1:0] D_ALL    = '1;
  localparam logic [AW-1:0] D_LO     = AW'(LO_MARK);
  localparam logic [AW-1:0] D_HI     = AW'(HI_MARK);

  logic [CW-1:0] wcnt;
  logic [AW:0]   rcnt;
  logic          ovr_set;
  logic [AW-1:0] diff;

  assign store_en = wr_fire && !ovr && (wcnt < WC_DEPTH);
  assign ovr_set  = wr_fire && !ovr && (wcnt == WC_TRIP);
  assign stored   = ovr ? '0 :
                    ((wcnt > WC_DEPTH) ? (AW+1)'(DEPTH) : (AW+1)'(wcnt));
  assign rd_adv   = rd_req && (rcnt < stored) && !ovr_set;
  assign drained  = closed && (rcnt == stored);
  assign extra_rd = rd_req && drained;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wp <= '0; rp <= '0; wcnt <= '0; rcnt <= '0;
      ovr <= 1'b0; closed <= 1'b0;
    end else begin
      if (wr_fire && wcnt != WC_MAX) wcnt <= wcnt + 1'b1;
      if (wr_fire && wr_last) closed <= 1'b1;
      if (ovr_set) begin
        ovr  <= 1'b1;
        wp   <= rp;
        rcnt <= '0;
      end else begin
        if (store_en) wp <= wp + 1'b1;
        if (rd_adv) begin
          rp   <= rp + 1'b1;
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  assign diff   = wp - rp;
  assign f_ne0  = (diff != '0);
  assign f_ne15 = (diff != D_ALL);
  assign f_ge4  = (diff >= D_LO);
  assign f_le11 = (diff <= D_HI);

  AST_DIFF_GROWS: assert property (@(posedge clk) disable iff (rst)
    (store_en && !rd_adv && !clear) |=> (diff == AW'($past(diff) + 1'b1))) else $error("diff"); // R3
  AST_DRAINED_HOLDS_RP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_adv && !clear) |=> $stable(rp)) else $error("rp moved"); // R7
  AST_SEVENTEENTH_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !ovr && wcnt == WC_DEPTH && !clear) |=> ($stable(wp) && !ovr)) else $error("17th"); // R4
  AST_OVR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (ovr_set && !clear) |=> (wp == rp && stored == '0)) else $error("ovr discard"); // R4
endmodule

// File: rtl/rxb_status.sv
module rxb_status
  import rxb_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          closed,
  input  logic          coll,
  input  logic          mis_last,
  input  logic          extra_rd,
  input  logic          ovr,
  input  logic [AW:0]   stored,
  output logic [15:0]   status
);
  logic              jam;
  logic              align;
  logic [EXC_W-1:0]  excess;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      jam <= 1'b0; align <= 1'b0; excess <= '0;
    end else begin
      if (coll && !closed) jam <= 1'b1;
      if (mis_last) align <= 1'b1;
      if (extra_rd && excess != '1) excess <= excess + 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[ST_JAM]   = jam;
    status[ST_OVR]   = ovr;
    status[ST_ALIGN] = align;
    status[ST_EXC_LO +: EXC_W] = excess;
    status[AW:0] = stored;
  end

  AST_PURGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!jam && !align && excess == '0)) else $error("purge"); // R9
  AST_EXCESS_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (excess == '1 && !clear) |=> (excess == '1)) else $error("excess"); // R7
endmodule

// File: rtl/rx_word_buffer.sv
module rx_word_buffer
  import rxb_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  input  logic        in_last,
  input  logic        in_misalign,
  input  logic        in_collision,
  input  logic        rd_valid,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  output logic        rd_par,
  input  logic        purge_en,
  input  logic        done_pkt,
  output logic        attn,
  output logic        diff_ne0,
  output logic        diff_ne15,
  output logic        diff_ge4,
  output logic        diff_le11
);
  localparam int DW = 16;

  logic          wr_fire, clear, rd_req;
  logic [AW-1:0] wp, rp;
  logic          store_en, rd_adv, extra_rd, closed, ovr, drained;
  logic [AW:0]   stored;
  logic [DW-1:0] mem_word;
  logic          mem_pbit;
  logic [15:0]   status;

  assign clear    = purge_en && done_pkt;
  assign in_ready = !closed;
  assign wr_fire  = in_valid && in_ready;
  assign rd_req   = rd_valid && (rd_sel == SEL_DATA);

  rxb_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_last(in_last),
    .rd_req(rd_req), .clear(clear), .wp(wp), .rp(rp),
    .store_en(store_en), .rd_adv(rd_adv), .extra_rd(extra_rd),
    .closed(closed), .ovr(ovr), .stored(stored), .drained(drained),
    .f_ne0(diff_ne0), .f_ne15(diff_ne15), .f_ge4(diff_ge4), .f_le11(diff_le11)
  );

  rxb_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .wr_en(store_en), .wr_ptr(wp), .wr_data(in_data),
    .rd_ptr(rp), .rd_word(mem_word), .rd_pbit(mem_pbit)
  );

  rxb_status #(.AW(AW)) u_stat (
    .clk(clk), .rst(rst), .clear(clear), .closed(closed),
    .coll(in_collision), .mis_last(wr_fire && in_last && in_misalign),
    .extra_rd(extra_rd), .ovr(ovr), .stored(stored), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_par  <= 1'b1;
    end else if (rd_valid && rd_sel == SEL_STAT) begin
      rd_data <= status;
      rd_par  <= odd_fill(status);
    end else if (rd_adv) begin
      rd_data <= mem_word;
      rd_par  <= mem_pbit;
    end
  end

  assign attn = drained;

  AST_READY_DROPS_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && in_last && !clear) |=> !in_ready) else $error("ready"); // R8
  AST_ODD_READBACK: assert property (@(posedge clk) disable iff (rst)
    rd_adv |=> (^{rd_data, rd_par})) else $error("parity"); // R2
  AST_IDLE_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_adv) |=> ($stable(rd_data) && $stable(rd_par))) else $error("hold"); // R7
endmodule

// File: tb/sim_rx_word_buffer.sv
module sim_rx_word_buffer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_last = 0, in_misalign = 0, in_collision = 0;
  logic [15:0] in_data = '0;
  logic rd_valid = 0, rd_sel = 0, purge_en = 0, done_pkt = 0;
  logic in_ready, rd_par, attn, diff_ne0, diff_ne15, diff_ge4, diff_le11;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_word_buffer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_misalign(in_misalign),
    .in_collision(in_collision), .rd_valid(rd_valid), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_par(rd_par), .purge_en(purge_en),
    .done_pkt(done_pkt), .attn(attn), .diff_ne0(diff_ne0),
    .diff_ne15(diff_ne15), .diff_ge4(diff_ge4), .diff_le11(diff_le11)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int base, input int i);
    return 16'(base + i * 16'h0301);
  endfunction

  function automatic logic [15:0] sw(input bit jam, input bit ovr, input bit al,
                                     input int ex, input int cnt);
    logic [15:0] s = '0;
    s[15] = jam; s[13] = ovr; s[8] = al;
    s[7:6] = 2'(ex); s[4:0] = 5'(cnt);
    return s;
  endfunction

  task automatic push(input logic [15:0] d, input bit last, input bit mis, input bit col);
    in_valid = 1; in_data = d; in_last = last; in_misalign = mis; in_collision = col;
    @(negedge clk);
    in_valid = 0; in_last = 0; in_misalign = 0; in_collision = 0;
  endtask

  task automatic rd(input bit sel);
    rd_valid = 1; rd_sel = sel;
    @(negedge clk);
    rd_valid = 0; rd_sel = 0;
  endtask

  task automatic chk_flags(input string tag, input int d);
    chk({tag, " R3 ne0"},  diff_ne0,  d != 0);
    chk({tag, " R3 ne15"}, diff_ne15, d != 15);
    chk({tag, " R3 ge4"},  diff_ge4,  d >= 4);
    chk({tag, " R3 le11"}, diff_le11, d <= 11);
  endtask

  task automatic chk_par(input string tag);
    chk({tag, " R2 parity"}, ^{rd_data, rd_par}, 1);
  endtask

  task automatic purge();
    purge_en = 1; done_pkt = 1;
    @(negedge clk);
    purge_en = 0; done_pkt = 0;
    rd(1);
    chk("R9 status cleared", rd_data, 16'h0000);
    chk("R9 ready reopened", in_ready, 1);
    chk("R9 attn cleared", attn, 0);
    chk_flags("R9", 0);
  endtask

  task automatic t_reset();
    chk("R1 ready", in_ready, 1);
    chk("R1 attn", attn, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_par", rd_par, 1);
    chk_flags("R1", 0);
  endtask

  task automatic t_fill16();
    for (int k = 1; k <= 16; k++) begin
      push(word_of(16'h1000, k), k == 16, 0, 0);
      chk_flags($sformatf("fill k=%0d", k), k % 16);
    end
    chk("R8 ready low after last", in_ready, 0);
    chk("R6 attn before reads", attn, 0);
    for (int k = 1; k <= 16; k++) begin
      rd(0);
      chk($sformatf("R2 word %0d", k), rd_data, word_of(16'h1000, k));
      chk_par("fill");
      chk_flags($sformatf("drain k=%0d", k), (16 - k) % 16);
    end
    chk("R6 attn after drain", attn, 1);
    rd(1);
    chk("R5 status 16", rd_data, sw(0, 0, 0, 0, 16));
    chk("R5 status parity", ^{rd_data, rd_par}, 1);
    purge();
  endtask

  task automatic t_short();
    for (int k = 1; k <= 5; k++) push(word_of(16'h2A55, k), k == 5, 0, 0);
    chk_flags("short", 5);
    for (int k = 1; k <= 5; k++) begin
      chk("R6 attn pending", attn, 0);
      rd(0);
      chk($sformatf("R2 short word %0d", k), rd_data, word_of(16'h2A55, k));
      chk_par("short");
    end
    chk("R6 attn", attn, 1);
    rd(0); rd(0);
    chk("R7 held data", rd_data, word_of(16'h2A55, 5));
    chk_flags("R7 extra", 0);
    rd(1);
    chk("R7 R5 excess 2", rd_data, sw(0, 0, 0, 2, 5));
    rd(0); rd(0); rd(0);
    rd(1);
    chk("R7 excess saturates", rd_data, sw(0, 0, 0, 3, 5));
    purge();
  endtask

  task automatic t_seventeen();
    for (int k = 1; k <= 17; k++) push(word_of(16'h0777, k), k == 17, 0, 0);
    rd(1);
    chk("R4 17 no overrun", rd_data, sw(0, 0, 0, 0, 16));
    for (int k = 1; k <= 16; k++) begin
      rd(0);
      chk($sformatf("R4 17-pkt word %0d", k), rd_data, word_of(16'h0777, k));
    end
    chk("R4 17 attn", attn, 1);
    purge();
  endtask

  task automatic t_overrun();
    logic [15:0] held;
    for (int k = 1; k <= 18; k++) push(word_of(16'h4000, k), k == 18, 0, 0);
    chk("R6 overrun attn", attn, 1);
    chk_flags("R4 overrun", 0);
    rd(1);
    chk("R4 overrun status", rd_data, sw(0, 1, 0, 0, 0));
    held = rd_data;
    rd(0);
    chk("R4 discarded data", rd_data, held);
    purge();
  endtask

  task automatic t_errors();
    logic [15:0] s;
    push(word_of(16'h0F0F, 1), 0, 0, 0);
    push(word_of(16'h0F0F, 2), 0, 0, 1);
    push(word_of(16'h0F0F, 3), 1, 1, 0);
    chk("R8 ready low", in_ready, 0);
    push(16'hDEAD, 1, 0, 0);
    chk_flags("R8 ignored", 3);
    rd(1);
    s = sw(1, 0, 1, 0, 3);
    chk("R5 jam+align", rd_data, s);
    done_pkt = 1;
    @(negedge clk);
    done_pkt = 0;
    rd(1);
    chk("R9 done w/o purge", rd_data, s);
    chk("R9 ready still low", in_ready, 0);
    purge();
    rd(0);
    chk("R7 empty read holds", rd_data, 16'h0000);
    chk_flags("R7 empty", 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fill16();
    t_short();
    t_seventeen();
    t_overrun();
    t_errors();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule